// File: doc/BRIEF.md
# Vector Instruction Sequencer with Optional Chaining

This block issues decoded vector instructions, in program order, to a vector unit whose registers hold `VLEN` elements spread across `LANES` lanes. A register is therefore processed as `NG = VLEN/LANES` element groups, one group per cycle. Four operations are supported: vector load, vector store, vector-vector add and vector-scalar subtract. There is one ALU unit and one load/store unit. An instruction is held at the input until its unit is free, its source registers are ready and its destination has no pending writes. It then streams its groups through a read stage, an execute or memory stage of fixed latency, and a writeback stage. Memory itself is not modelled; the load/store unit is a fixed-latency delay.

The parameter `CHAIN` selects the forwarding policy. With it at 0, a consumer waits until its producer has written every group. With it at 1, a consumer may start in the same cycle as the producer's first group is written, because both stream at one group per cycle. A per-register scoreboard counts the groups already written and drives both policies. The block reports per-cycle read activity and writeback events for each unit, and it raises a separate signal that tells the scalar side it may keep running while a vector instruction stalls.

Top module: `vec_seq`

## Requirements
- R1: An instruction on `in_valid` is accepted in exactly the cycle `in_ready` is high. At most one is accepted per cycle, in the order presented. The op codes are 0 = load, 1 = store, 2 = vector add, 3 = vector-scalar subtract. Loads and stores use the memory unit; add and subtract use the ALU.
- R2: An accepted instruction reads its groups 0 to NG-1 in ascending order on its unit (`alu_rd`/`alu_grp` or `mem_rd`/`mem_grp`), one per cycle, starting in the acceptance cycle.
- R3: Group g is written back LAT+1 cycles after it is read: 5 cycles for loads (MEM_LAT=4) and 2 cycles for ALU ops (ALU_LAT=1). The writeback names the destination register and g. A store produces no writeback.
- R4: An instruction is not accepted while its unit still has groups of an earlier instruction to read. It is accepted in the cycle right after that unit's last group read, with no idle cycle.
- R5: With CHAIN=0, an instruction whose source has pending writes is accepted no earlier than the cycle after that source's last group writeback.
- R6: With CHAIN=1, such an instruction may be accepted in the cycle in which group 0 of its source is written back.
- R7: An instruction that writes a register with pending writes is accepted no earlier than the cycle after that register's last writeback. No two units ever write the same register in the same cycle.
- R8: Instructions on different units overlap. An independent ALU op presented right after a load is accepted in the next cycle.
- R9: `scalar_go` is high in every cycle outside reset, including cycles in which a vector instruction is stalled.
- R10: After reset, no unit reads or writes, the scoreboard is clear, and the first instruction is accepted in the cycle it is presented.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Instruction presented |
| in_op | input | 2 | Op code (see R1) |
| in_dst | input | RW | Destination register |
| in_src_a | input | RW | First source register (store data, add/sub operand) |
| in_src_b | input | RW | Second source register (add only) |
| in_ready | output | 1 | Instruction accepted this cycle |
| scalar_go | output | 1 | Scalar side may proceed |
| alu_rd | output | 1 | ALU reads a group this cycle |
| alu_grp | output | GW | Group read by the ALU |
| mem_rd | output | 1 | Load/store unit reads a group this cycle |
| mem_grp | output | GW | Group read by the load/store unit |
| alu_wb | output | 1 | ALU writeback this cycle |
| alu_wb_reg | output | RW | ALU writeback register |
| alu_wb_grp | output | GW | ALU writeback group |
| mem_wb | output | 1 | Load writeback this cycle |
| mem_wb_reg | output | RW | Load writeback register |
| mem_wb_grp | output | GW | Load writeback group |

## Verification
The bench targets the stall boundaries. A second load must start exactly NG cycles after the first; a design that allowed dead time would start one cycle late, and one that allowed overlap would mix two instructions' groups on one unit. A dependent add behind a load must start exactly one cycle after the last load writeback without chaining, and exactly at the first writeback with chaining. An off-by-one in the scoreboard count or a missed same-cycle writeback would shift that start by a cycle or let the add read stale groups. The bench also covers an ALU writer that targets a register a load is still filling; a design without the destination check would let the faster ALU write first and then be overwritten by the load.

// File: rtl/vseq_pkg.sv
package vseq_pkg;

    typedef enum logic [1:0] {
        OP_LOAD  = 2'd0,
        OP_STORE = 2'd1,
        OP_ADDVV = 2'd2,
        OP_SUBVS = 2'd3
    } vop_e;

    localparam int N_UNITS  = 2;
    localparam int UNIT_ALU = 0;
    localparam int UNIT_MEM = 1;

    function automatic logic op_on_mem(input vop_e op);
        return (op == OP_LOAD) || (op == OP_STORE);
    endfunction

    function automatic logic op_writes(input vop_e op);
        return op != OP_STORE;
    endfunction

    function automatic logic op_reads_a(input vop_e op);
        return op != OP_LOAD;
    endfunction

    function automatic logic op_reads_b(input vop_e op);
        return op == OP_ADDVV;
    endfunction

endpackage

// File: rtl/vseq_unit.sv
module vseq_unit #(
    parameter int NG  = 4,
    parameter int GW  = 2,
    parameter int RW  = 3,
    parameter int LAT = 1
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          start,
    input  logic          start_wr,
    input  logic [RW-1:0] start_dst,
    output logic          free,
    output logic          rd_v,
    output logic [GW-1:0] rd_grp,
    output logic          wb_v,
    output logic [RW-1:0] wb_reg,
    output logic [GW-1:0] wb_grp
);
    localparam int DEP = LAT + 1;
    localparam int EW  = 1 + RW + GW;

    logic          active;
    logic [GW-1:0] gcnt;
    logic          cur_wr;
    logic [RW-1:0] cur_dst;
    logic          rd_wr;
    logic [RW-1:0] rd_dst;
    logic [EW-1:0] stage [DEP];

    assign free   = !active;
    assign rd_v   = start || active;
    assign rd_grp = start ? '0 : gcnt;
    assign rd_wr  = start ? start_wr : cur_wr;
    assign rd_dst = start ? start_dst : cur_dst;

    always_ff @(posedge clk) begin
        if (rst) begin
            active  <= 1'b0;
            gcnt    <= '0;
            cur_wr  <= 1'b0;
            cur_dst <= '0;
        end else if (start) begin
            cur_wr  <= start_wr;
            cur_dst <= start_dst;
            if (NG > 1) begin
                active <= 1'b1;
                gcnt   <= GW'(1);
            end
        end else if (active) begin
            if (gcnt == GW'(NG - 1)) begin
                active <= 1'b0;
                gcnt   <= '0;
            end else begin
                gcnt <= gcnt + GW'(1);
            end
        end
    end

    // Delay line from read to writeback: execute/memory stages then W.
    for (genvar k = 0; k < DEP; k++) begin : g_stage
        always_ff @(posedge clk) begin
            if (rst) begin
                stage[k] <= '0;
            end else if (k == 0) begin
                stage[k] <= {rd_v && rd_wr, rd_dst, rd_grp};
            end else begin
                stage[k] <= stage[(k == 0) ? 0 : k - 1];
            end
        end
    end

    assign wb_v   = stage[DEP-1][EW-1];
    assign wb_reg = stage[DEP-1][GW +: RW];
    assign wb_grp = stage[DEP-1][GW-1:0];

endmodule

// File: rtl/vseq_sb.sv
module vseq_sb #(
    parameter int NREGS = 8,
    parameter int RW    = 3,
    parameter int NG    = 4,
    parameter int NWP   = 2
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     set_v,
    input  logic [RW-1:0]            set_reg,
    input  logic [NWP-1:0]           wb_v,
    input  logic [NWP-1:0][RW-1:0]   wb_reg,
    output logic [NREGS-1:0]         busy,
    output logic [NREGS-1:0]         started,
    output logic [NREGS-1:0]         hit
);
    localparam int CW = $clog2(NG + 1);

    for (genvar r = 0; r < NREGS; r++) begin : g_reg
        logic [CW-1:0]  cnt;
        logic [NWP-1:0] match;

        for (genvar p = 0; p < NWP; p++) begin : g_port
            assign match[p] = wb_v[p] && (wb_reg[p] == RW'(r));
        end

        assign hit[r]     = |match;
        assign started[r] = cnt != '0;

        always_ff @(posedge clk) begin
            if (rst) begin
                busy[r] <= 1'b0;
                cnt     <= '0;
            end else if (set_v && set_reg == RW'(r)) begin
                busy[r] <= 1'b1;
                cnt     <= '0;
            end else if (hit[r]) begin
                if (cnt == CW'(NG - 1)) begin
                    busy[r] <= 1'b0;
                    cnt     <= '0;
                end else begin
                    cnt <= cnt + CW'(1);
                end
            end
        end
    end

endmodule

// File: rtl/vec_seq.sv
module vec_seq
    import vseq_pkg::*;
#(
    parameter int LANES   = 8,
    parameter int VLEN    = 32,
    parameter int NREGS   = 8,
    parameter int MEM_LAT = 4,
    parameter int ALU_LAT = 1,
    parameter bit CHAIN   = 1'b0,
    localparam int NG     = VLEN / LANES,
    localparam int GW     = (NG > 1) ? $clog2(NG) : 1,
    localparam int RW     = (NREGS > 1) ? $clog2(NREGS) : 1
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          in_valid,
    input  logic [1:0]    in_op,
    input  logic [RW-1:0] in_dst,
    input  logic [RW-1:0] in_src_a,
    input  logic [RW-1:0] in_src_b,
    output logic          in_ready,
    output logic          scalar_go,
    output logic          alu_rd,
    output logic [GW-1:0] alu_grp,
    output logic          mem_rd,
    output logic [GW-1:0] mem_grp,
    output logic          alu_wb,
    output logic [RW-1:0] alu_wb_reg,
    output logic [GW-1:0] alu_wb_grp,
    output logic          mem_wb,
    output logic [RW-1:0] mem_wb_reg,
    output logic [GW-1:0] mem_wb_grp
);
    vop_e                         op;
    logic                         mem_op;
    logic                         unit_free;
    logic                         ok_a, ok_b, ok_d;
    logic                         issue;
    logic [NREGS-1:0]             busy, started, hit, src_rdy;
    logic [N_UNITS-1:0]           u_start, u_free, u_rd, u_wb;
    logic [GW-1:0]                u_rdg [N_UNITS];
    logic [GW-1:0]                u_wbg [N_UNITS];
    logic [N_UNITS-1:0][RW-1:0]   u_wbr;

    assign op     = vop_e'(in_op);
    assign mem_op = op_on_mem(op);

    // Forwarding policy picked by parameter.
    if (CHAIN) begin : g_chain
        assign src_rdy = ~busy | started | hit;
    end else begin : g_nochain
        assign src_rdy = ~busy;
    end

    always_comb begin
        unit_free = mem_op ? u_free[UNIT_MEM] : u_free[UNIT_ALU];
        ok_a      = !op_reads_a(op) || src_rdy[in_src_a];
        ok_b      = !op_reads_b(op) || src_rdy[in_src_b];
        ok_d      = !op_writes(op) || !busy[in_dst];
        issue     = in_valid && unit_free && ok_a && ok_b && ok_d;
    end

    assign in_ready  = issue;
    assign scalar_go = !rst;

    for (genvar u = 0; u < N_UNITS; u++) begin : g_unit
        assign u_start[u] = issue && (mem_op == (u == UNIT_MEM));
        vseq_unit #(
            .NG (NG),
            .GW (GW),
            .RW (RW),
            .LAT((u == UNIT_MEM) ? MEM_LAT : ALU_LAT)
        ) u_unit (
            .clk      (clk),
            .rst      (rst),
            .start    (u_start[u]),
            .start_wr (op_writes(op)),
            .start_dst(in_dst),
            .free     (u_free[u]),
            .rd_v     (u_rd[u]),
            .rd_grp   (u_rdg[u]),
            .wb_v     (u_wb[u]),
            .wb_reg   (u_wbr[u]),
            .wb_grp   (u_wbg[u])
        );
    end

    vseq_sb #(
        .NREGS(NREGS),
        .RW   (RW),
        .NG   (NG),
        .NWP  (N_UNITS)
    ) u_sb (
        .clk    (clk),
        .rst    (rst),
        .set_v  (issue && op_writes(op)),
        .set_reg(in_dst),
        .wb_v   (u_wb),
        .wb_reg (u_wbr),
        .busy   (busy),
        .started(started),
        .hit    (hit)
    );

    assign alu_rd     = u_rd[UNIT_ALU];
    assign alu_grp    = u_rdg[UNIT_ALU];
    assign mem_rd     = u_rd[UNIT_MEM];
    assign mem_grp    = u_rdg[UNIT_MEM];
    assign alu_wb     = u_wb[UNIT_ALU];
    assign alu_wb_reg = u_wbr[UNIT_ALU];
    assign alu_wb_grp = u_wbg[UNIT_ALU];
    assign mem_wb     = u_wb[UNIT_MEM];
    assign mem_wb_reg = u_wbr[UNIT_MEM];
    assign mem_wb_grp = u_wbg[UNIT_MEM];

endmodule

// File: rtl/vec_seq_chk.sv
module vec_seq_chk #(
    parameter int NG = 4,
    parameter int GW = 2,
    parameter int RW = 3
) (
    input logic          clk,
    input logic          rst,
    input logic          in_valid,
    input logic [1:0]    in_op,
    input logic          in_ready,
    input logic          scalar_go,
    input logic          alu_rd,
    input logic [GW-1:0] alu_grp,
    input logic          mem_rd,
    input logic [GW-1:0] mem_grp,
    input logic          alu_wb,
    input logic [RW-1:0] alu_wb_reg,
    input logic [GW-1:0] alu_wb_grp,
    input logic          mem_wb,
    input logic [RW-1:0] mem_wb_reg,
    input logic [GW-1:0] mem_wb_grp
);
    // R1
    accept_needs_valid_chk: assert property (@(posedge clk) disable iff (rst)
        in_ready |-> in_valid);

    // R2
    alu_grp_step_chk: assert property (@(posedge clk) disable iff (rst)
        (alu_rd && alu_grp != GW'(NG - 1)) |=> (alu_rd && alu_grp == GW'($past(alu_grp) + GW'(1))));

    // R2
    mem_grp_step_chk: assert property (@(posedge clk) disable iff (rst)
        (mem_rd && mem_grp != GW'(NG - 1)) |=> (mem_rd && mem_grp == GW'($past(mem_grp) + GW'(1))));

    // R3
    mem_wb_stream_chk: assert property (@(posedge clk) disable iff (rst)
        (mem_wb && mem_wb_grp != '0) |-> ($past(mem_wb) && mem_wb_grp == GW'($past(mem_wb_grp) + GW'(1))));

    // R3
    alu_wb_stream_chk: assert property (@(posedge clk) disable iff (rst)
        (alu_wb && alu_wb_grp != '0) |-> ($past(alu_wb) && alu_wb_grp == GW'($past(alu_wb_grp) + GW'(1))));

    // R4
    mem_unit_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (mem_rd && mem_grp != GW'(NG - 1)) |=> !(in_ready && in_op[1] == 1'b0));

    // R4
    alu_unit_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (alu_rd && alu_grp != GW'(NG - 1)) |=> !(in_ready && in_op[1] == 1'b1));

    // R7
    wb_same_reg_chk: assert property (@(posedge clk) disable iff (rst)
        !(alu_wb && mem_wb && alu_wb_reg == mem_wb_reg));

    // R9
    scalar_free_chk: assert property (@(posedge clk) disable iff (rst)
        (in_valid && !in_ready) |-> scalar_go);

endmodule

bind vec_seq vec_seq_chk #(.NG(NG), .GW(GW), .RW(RW)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .in_valid  (in_valid),
    .in_op     (in_op),
    .in_ready  (in_ready),
    .scalar_go (scalar_go),
    .alu_rd    (alu_rd),
    .alu_grp   (alu_grp),
    .mem_rd    (mem_rd),
    .mem_grp   (mem_grp),
    .alu_wb    (alu_wb),
    .alu_wb_reg(alu_wb_reg),
    .alu_wb_grp(alu_wb_grp),
    .mem_wb    (mem_wb),
    .mem_wb_reg(mem_wb_reg),
    .mem_wb_grp(mem_wb_grp)
);

// File: tb/vec_seq_tb.sv
`timescale 1ns/1ps
module vec_seq_tb;
    localparam int NG   = 4;
    localparam int MLAT = 4;
    localparam int ALAT = 1;
    localparam int RING = 128;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #5 clk = ~clk;

    int cyc = 0;
    always @(posedge clk) cyc <= cyc + 1;

    int total = 0;
    int bad   = 0;
    bit mon_en = 1'b0;

    // Index 0: no chaining (u_dut), index 1: chaining (u_dut_ch).
    logic       iv   [2];
    logic [1:0] iop  [2];
    logic [2:0] idst [2], isa [2], isb [2];
    logic       ordy [2], sgo [2], ard [2], mrd [2], awv [2], mwv [2];
    logic [1:0] ag   [2], mg  [2], awg [2], mwg [2];
    logic [2:0] awr  [2], mwr [2];

    vec_seq #(.CHAIN(1'b0)) u_dut (
        .clk(clk), .rst(rst), .in_valid(iv[0]), .in_op(iop[0]), .in_dst(idst[0]),
        .in_src_a(isa[0]), .in_src_b(isb[0]), .in_ready(ordy[0]), .scalar_go(sgo[0]),
        .alu_rd(ard[0]), .alu_grp(ag[0]), .mem_rd(mrd[0]), .mem_grp(mg[0]),
        .alu_wb(awv[0]), .alu_wb_reg(awr[0]), .alu_wb_grp(awg[0]),
        .mem_wb(mwv[0]), .mem_wb_reg(mwr[0]), .mem_wb_grp(mwg[0]));

    vec_seq #(.CHAIN(1'b1)) u_dut_ch (
        .clk(clk), .rst(rst), .in_valid(iv[1]), .in_op(iop[1]), .in_dst(idst[1]),
        .in_src_a(isa[1]), .in_src_b(isb[1]), .in_ready(ordy[1]), .scalar_go(sgo[1]),
        .alu_rd(ard[1]), .alu_grp(ag[1]), .mem_rd(mrd[1]), .mem_grp(mg[1]),
        .alu_wb(awv[1]), .alu_wb_reg(awr[1]), .alu_wb_grp(awg[1]),
        .mem_wb(mwv[1]), .mem_wb_reg(mwr[1]), .mem_wb_grp(mwg[1]));

    // Expected per-cycle activity, ring indexed by cycle.
    bit       e_ard [2][RING], e_mrd [2][RING], e_awv [2][RING], e_mwv [2][RING];
    int       e_ag  [2][RING], e_mg  [2][RING], e_awg [2][RING], e_mwg [2][RING];
    int       e_awr [2][RING], e_mwr [2][RING];

    // Timing model state.
    int w0 [2][8];
    int wl [2][8];
    int nf [2][2];
    int last_iss [2];

    function automatic bit rd_a(int op); return op != 0; endfunction
    function automatic bit rd_b(int op); return op == 2; endfunction
    function automatic bit wr_d(int op); return op != 1; endfunction

    task automatic chk(string tag, int act, int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s: got %0d expected %0d (cycle %0d)", tag, act, exp, cyc);
        end
    endtask

    always @(negedge clk) begin
        if (mon_en) begin
            for (int k = 0; k < 2; k++) begin
                int s;
                s = cyc % RING;
                total += 4;
                if (ard[k] !== e_ard[k][s] || (e_ard[k][s] && int'(ag[k]) != e_ag[k][s])) begin
                    bad++;
                    $display("FAIL R2 dut%0d alu read: got %0b/%0d expected %0b/%0d (cycle %0d)",
                             k, ard[k], ag[k], e_ard[k][s], e_ag[k][s], cyc);
                end
                if (mrd[k] !== e_mrd[k][s] || (e_mrd[k][s] && int'(mg[k]) != e_mg[k][s])) begin
                    bad++;
                    $display("FAIL R2 dut%0d mem read: got %0b/%0d expected %0b/%0d (cycle %0d)",
                             k, mrd[k], mg[k], e_mrd[k][s], e_mg[k][s], cyc);
                end
                if (awv[k] !== e_awv[k][s] ||
                    (e_awv[k][s] && (int'(awr[k]) != e_awr[k][s] || int'(awg[k]) != e_awg[k][s]))) begin
                    bad++;
                    $display("FAIL R3 dut%0d alu wb: got %0b r%0d g%0d expected %0b r%0d g%0d (cycle %0d)",
                             k, awv[k], awr[k], awg[k], e_awv[k][s], e_awr[k][s], e_awg[k][s], cyc);
                end
                if (mwv[k] !== e_mwv[k][s] ||
                    (e_mwv[k][s] && (int'(mwr[k]) != e_mwr[k][s] || int'(mwg[k]) != e_mwg[k][s]))) begin
                    bad++;
                    $display("FAIL R3 dut%0d mem wb: got %0b r%0d g%0d expected %0b r%0d g%0d (cycle %0d)",
                             k, mwv[k], mwr[k], mwg[k], e_mwv[k][s], e_mwr[k][s], e_mwg[k][s], cyc);
                end
                e_ard[k][s] = 0; e_mrd[k][s] = 0; e_awv[k][s] = 0; e_mwv[k][s] = 0;
            end
        end
    end

    // Present one instruction, predict its acceptance cycle and activity.
    task automatic issue(int k, int op, int d, int a, int b);
        int p, e, u, lat, need, guard;
        string tag;
        bit ch;
        ch  = (k == 1);
        p   = cyc;
        u   = (op <= 1) ? 1 : 0;
        lat = u ? MLAT : ALAT;
        e   = p;
        tag = "R1";
        if (nf[k][u] > e) begin e = nf[k][u]; tag = "R4"; end
        if (rd_a(op)) begin
            need = ch ? w0[k][a] : wl[k][a] + 1;
            if (need > e) begin e = need; tag = ch ? "R6" : "R5"; end
        end
        if (rd_b(op)) begin
            need = ch ? w0[k][b] : wl[k][b] + 1;
            if (need > e) begin e = need; tag = ch ? "R6" : "R5"; end
        end
        if (wr_d(op)) begin
            need = wl[k][d] + 1;
            if (need > e) begin e = need; tag = "R7"; end
        end
        for (int g = 0; g < NG; g++) begin
            int s, w;
            s = (e + g) % RING;
            w = (e + g + lat + 1) % RING;
            if (u == 1) begin e_mrd[k][s] = 1; e_mg[k][s] = g; end
            else        begin e_ard[k][s] = 1; e_ag[k][s] = g; end
            if (wr_d(op)) begin
                if (u == 1) begin e_mwv[k][w] = 1; e_mwr[k][w] = d; e_mwg[k][w] = g; end
                else        begin e_awv[k][w] = 1; e_awr[k][w] = d; e_awg[k][w] = g; end
            end
        end
        nf[k][u] = e + NG;
        if (wr_d(op)) begin
            w0[k][d] = e + lat + 1;
            wl[k][d] = e + NG + lat;
        end
        iv[k] = 1'b1; iop[k] = 2'(op); idst[k] = 3'(d); isa[k] = 3'(a); isb[k] = 3'(b);
        guard = 0;
        forever begin
            @(negedge clk);
            if (!ordy[k]) chk("R9 scalar_go during stall", int'(sgo[k]), 1);
            if (ordy[k] || guard > 300) break;
            guard++;
        end
        chk({tag, " accept cycle"}, cyc, e);
        last_iss[k] = cyc;
        @(posedge clk); #1;
        iv[k] = 1'b0;
    endtask

    initial begin
        int seed_dummy;
        for (int k = 0; k < 2; k++) begin
            iv[k] = 0; iop[k] = 0; idst[k] = 0; isa[k] = 0; isb[k] = 0;
            nf[k][0] = 0; nf[k][1] = 0; last_iss[k] = 0;
            for (int r = 0; r < 8; r++) begin w0[k][r] = -100; wl[k][r] = -100; end
            for (int s = 0; s < RING; s++) begin
                e_ard[k][s] = 0; e_mrd[k][s] = 0; e_awv[k][s] = 0; e_mwv[k][s] = 0;
                e_ag[k][s] = 0; e_mg[k][s] = 0; e_awg[k][s] = 0; e_mwg[k][s] = 0;
                e_awr[k][s] = 0; e_mwr[k][s] = 0;
            end
        end
        seed_dummy = int'($urandom(32'h5eed_0042));
        repeat (4) @(posedge clk);
        #1 rst = 1'b0;
        mon_en = 1'b1;
        @(negedge clk);
        // R10: idle after reset
        for (int k = 0; k < 2; k++) begin
            chk("R10 reset idle reads", int'(ard[k]) + int'(mrd[k]), 0);
            chk("R10 reset idle wb", int'(awv[k]) + int'(mwv[k]), 0);
            chk("R10 reset in_ready", int'(ordy[k]), 0);
            chk("R9 scalar_go after reset", int'(sgo[k]), 1);
        end
        @(posedge clk); #1;

        for (int k = 0; k < 2; k++) begin
            int p0, lv2, lv5;
            // R10: first instruction accepted at once
            p0 = cyc;
            issue(k, 0, 1, 0, 0);
            chk("R10 first accept", last_iss[k], p0);
            issue(k, 0, 2, 0, 0);
            lv2 = last_iss[k];
            chk("R4 back-to-back loads", lv2, p0 + NG);
            issue(k, 2, 3, 1, 2);
            if (k == 0) chk("R5 add after last load wb", last_iss[k], lv2 + NG + MLAT + 1);
            else        chk("R6 chained add at first wb", last_iss[k], lv2 + MLAT + 1);
            issue(k, 3, 4, 3, 0);
            issue(k, 1, 0, 4, 0);
            repeat (20) @(posedge clk); #1;
            issue(k, 0, 5, 0, 0);
            lv5 = last_iss[k];
            issue(k, 2, 6, 0, 7);
            chk("R8 alu overlaps load", last_iss[k], lv5 + 1);
            issue(k, 2, 5, 0, 0);
            chk("R7 writer waits for pending load", last_iss[k], lv5 + NG + MLAT + 1);
            repeat (20) @(posedge clk); #1;
            for (int n = 0; n < 120; n++) begin
                issue(k, int'($urandom_range(3, 0)), int'($urandom_range(7, 0)),
                      int'($urandom_range(7, 0)), int'($urandom_range(7, 0)));
            end
            repeat (20) @(posedge clk); #1;
        end
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (60000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule